// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. It puts a trial code on an external DAC and reads back one comparator bit that reports whether the held input sits at or above the DAC level. Starting from the most significant position, it settles one result bit per trial. It keeps the bit when the comparator says the input is high enough and clears it otherwise. When the last bit is settled it raises an end-of-conversion flag. It also presents the parallel result.

Resolution is picked per conversion: full 10-bit, or 8-bit for a shorter conversion that uses only the upper 8 DAC positions. Each decision is also streamed out serially, most significant first, with a valid strobe. A programmable number of settle cycles before each decision gives the analog path time to follow the new trial code. The DAC, comparator and sample-and-hold are outside this block.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy_o`, `eoc_o`, `ser_vld_o`, `dac_code_o` and `result_o` all become 0.
- R2: A `start_i` seen at a clock edge while idle is accepted. From the next cycle `busy_o` is 1, `eoc_o` is 0 and `dac_code_o` holds only its top bit (512 at 10 bits).
- R3: `cmp_i` = 1 means the input is at or above the current trial level. At each decision the bit under trial is kept if `cmp_i` is 1 and cleared if it is 0. The next lower bit is then set as the new trial. For an ideal comparator the result equals the input code.
- R4: Each bit takes `settle_i`+1 cycles, with `settle_i` sampled at the accepted start. `eoc_o` rises exactly N×(`settle_i`+1) cycles after the start edge, where N is 10 or 8.
- R5: `eoc_o` stays high until the next accepted start, and `busy_o` and `eoc_o` are never high together.
- R6: In 10-bit mode (`hi_res_i` = 1) with a 1 V full scale split into 1024 steps, a 0.6 V input resolves to 614.
- R7: In 8-bit mode (`hi_res_i` = 0) only DAC bits 9..2 are ever trialled, so bits 1..0 of `dac_code_o` stay 0 while busy. The 8-bit result appears on `result_o[7:0]` with `result_o[9:8]` = 0.
- R8: `hi_res_i` is sampled at the accepted start. Changing it during a conversion has no effect on that conversion.
- R9: A `start_i` seen while `busy_o` is high is ignored. The conversion keeps its timing and result.
- R10: After each decision, `ser_bit_o` carries the decided bit for one cycle with `ser_vld_o` high, most significant bit first. There are exactly N strobes, and the last one falls in the first cycle that `eoc_o` is high.
- R11: `result_o` keeps the previous result throughout a conversion and changes only when that conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request, taken only when idle |
| hi_res_i | input | 1 | 1 = 10-bit conversion, 0 = 8-bit conversion |
| settle_i | input | SETTLE_W | Extra settle cycles before each decision |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code_o | output | DATA_W | Trial code to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | End of conversion, held until the next start |
| result_o | output | DATA_W | Converted value, right-aligned in 8-bit mode |
| ser_bit_o | output | 1 | Most recently decided bit |
| ser_vld_o | output | 1 | Strobe qualifying `ser_bit_o` |

## Verification
The final decision produces two events on the same edge: the serial strobe for the least significant bit and the rise of end-of-conversion. The bench samples both in one cycle. It requires that they coincide, and that the word built from the strobes equals the parallel result. A second collision is a new request arriving while a conversion is under way, together with changes to resolution and settle time. The bench issues these a few cycles into selected conversions. It then judges the cycle count and the result against the values predicted from the original start settings.

// File: rtl/sar_pkg.sv
// sar_pkg: shared definitions for the successive-approximation controller.
// Assumes nothing beyond being compiled before the modules that import it.
package sar_pkg;

    // Phase of the converter as seen from outside.
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } sar_phase_e;

    // Number of bits resolved for a given resolution selection.
    function automatic int unsigned bits_for(input logic hires, input int unsigned full_w,
                                             input int unsigned low_w);
        return hires ? full_w : low_w;
    endfunction

endpackage

// File: rtl/sar_settle_timer.sv
// sar_settle_timer: counts down the settle cycles that precede each decision.
// Assumes reload_i wins over counting; zero_o is high when no wait remains.
module sar_settle_timer #(
    parameter int SETTLE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                reload_i,
    input  logic [SETTLE_W-1:0] reload_val_i,
    output logic                zero_o
);

    logic [SETTLE_W-1:0] cnt_q;

    // Reload on a new trial, otherwise count down while a conversion runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_i) begin
            cnt_q <= reload_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sar_bit_engine.sv
// sar_bit_engine: working register and trial pointer of the conversion.
// Assumes load_i and decide_i are never high together and that hires_i is
// stable for the whole conversion. The pointer is a one-hot mask on the bit
// under trial; the lowest position used depends on the resolution.
module sar_bit_engine #(
    parameter int DATA_W = 10,
    parameter int LOW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              decide_i,
    input  logic              cmp_i,
    input  logic              hires_i,
    output logic [DATA_W-1:0] code_o,
    output logic [DATA_W-1:0] decided_o,
    output logic              last_o
);

    localparam int SHIFT = DATA_W - LOW_W;
    localparam logic [DATA_W-1:0] TOP_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] work_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] work_d;

    assign last_o = hires_i ? mask_q[0] : mask_q[SHIFT];

    // Per bit: settle the bit under trial, and raise the next trial below it.
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign decided_o[i] = mask_q[i] ? cmp_i : work_q[i];
            if (i < DATA_W - 1) begin : g_trial
                assign work_d[i] = decided_o[i] | (mask_q[i+1] & ~last_o);
            end else begin : g_top
                assign work_d[i] = decided_o[i];
            end
        end
    endgenerate

    // Load the first trial on start; step one position per decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            mask_q <= '0;
        end else if (load_i) begin
            work_q <= TOP_ONLY;
            mask_q <= TOP_ONLY;
        end else if (decide_i) begin
            work_q <= work_d;
            mask_q <= last_o ? '0 : (mask_q >> 1);
        end
    end

    assign code_o = work_q;

endmodule

// File: rtl/sar_serial_out.sv
// sar_serial_out: registers each decided bit with a one-cycle strobe.
// Assumes at most one decision per cycle.
module sar_serial_out (
    input  logic clk,
    input  logic rst_n,
    input  logic decide_i,
    input  logic bit_i,
    output logic ser_bit_o,
    output logic ser_vld_o
);

    // Capture the decision and pulse the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_bit_o <= 1'b0;
            ser_vld_o <= 1'b0;
        end else begin
            ser_vld_o <= decide_i;
            if (decide_i) begin
                ser_bit_o <= bit_i;
            end
        end
    end

endmodule

// File: rtl/sar_ctrl.sv
// sar_ctrl: successive-approximation conversion controller (top).
// Drives the trial code to an external DAC and reads one comparator bit that
// is 1 when the held input is at or above the DAC level. Resolution and settle
// time are captured at start; starts while busy are dropped.
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int LOW_W    = 8,
    parameter int SETTLE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                hi_res_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                cmp_i,
    output logic [DATA_W-1:0]   dac_code_o,
    output logic                busy_o,
    output logic                eoc_o,
    output logic [DATA_W-1:0]   result_o,
    output logic                ser_bit_o,
    output logic                ser_vld_o
);

    localparam int SHIFT = DATA_W - LOW_W;

    sar_phase_e          phase_q;
    logic                eoc_q;
    logic                hires_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [DATA_W-1:0]   result_q;
    logic [DATA_W-1:0]   decided;
    logic [DATA_W-1:0]   packed_res;
    logic                last_bit;
    logic                tmr_zero;
    logic                accept;
    logic                decide;
    logic [SETTLE_W-1:0] reload_val;

    assign accept     = start_i && (phase_q == PH_IDLE);
    assign decide     = (phase_q == PH_CONV) && tmr_zero;
    assign reload_val = accept ? settle_i : settle_q;

    sar_settle_timer #(
        .SETTLE_W (SETTLE_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (phase_q == PH_CONV),
        .reload_i     (accept || decide),
        .reload_val_i (reload_val),
        .zero_o       (tmr_zero)
    );

    sar_bit_engine #(
        .DATA_W (DATA_W),
        .LOW_W  (LOW_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .decide_i  (decide),
        .cmp_i     (cmp_i),
        .hires_i   (hires_q),
        .code_o    (dac_code_o),
        .decided_o (decided),
        .last_o    (last_bit)
    );

    sar_serial_out u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .decide_i  (decide),
        .bit_i     (cmp_i),
        .ser_bit_o (ser_bit_o),
        .ser_vld_o (ser_vld_o)
    );

    // Right-align the short result when the narrow mode exists.
    generate
        if (SHIFT > 0) begin : g_narrow
            assign packed_res = hires_q ? decided
                                        : {{SHIFT{1'b0}}, decided[DATA_W-1:SHIFT]};
        end else begin : g_full
            assign packed_res = decided;
        end
    endgenerate

    // Phase, end flag and captured settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            eoc_q    <= 1'b0;
            hires_q  <= 1'b0;
            settle_q <= '0;
        end else if (accept) begin
            phase_q  <= PH_CONV;
            eoc_q    <= 1'b0;
            hires_q  <= hi_res_i;
            settle_q <= settle_i;
        end else if (decide && last_bit) begin
            phase_q  <= PH_IDLE;
            eoc_q    <= 1'b1;
        end
    end

    // Update the published result only when the last bit is decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (decide && last_bit) begin
            result_q <= packed_res;
        end
    end

    assign busy_o   = (phase_q == PH_CONV);
    assign eoc_o    = eoc_q;
    assign result_o = result_q;

endmodule

// File: rtl/sar_ctrl_chk.sv
// sar_ctrl_chk: temporal properties of sar_ctrl, attached with bind.
module sar_ctrl_chk #(
    parameter int DATA_W   = 10,
    parameter int LOW_W    = 8,
    parameter int SETTLE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              eoc_o,
    input logic [DATA_W-1:0] dac_code_o,
    input logic [DATA_W-1:0] result_o,
    input logic              ser_vld_o,
    input logic              hires_q
);

    localparam int SHIFT = DATA_W - LOW_W;
    localparam logic [DATA_W-1:0] TOP_ONLY = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((64'd1 << SHIFT) - 64'd1);

    AST_START_LOADS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !eoc_o && (dac_code_o == TOP_ONLY))); // R2

    AST_EOC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && !start_i) |=> eoc_o); // R5

    AST_BUSY_EOC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && eoc_o)); // R5

    AST_NARROW_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !hires_q) |-> ((dac_code_o & LOW_MASK) == '0)); // R7

    AST_NARROW_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_o && !hires_q) |-> ((result_o >> LOW_W) == '0)); // R7

    AST_STROBE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ser_vld_o |-> $past(busy_o)); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(result_o))); // R11

endmodule

bind sar_ctrl sar_ctrl_chk #(
    .DATA_W   (DATA_W),
    .LOW_W    (LOW_W),
    .SETTLE_W (SETTLE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .eoc_o      (eoc_o),
    .dac_code_o (dac_code_o),
    .result_o   (result_o),
    .ser_vld_o  (ser_vld_o),
    .hires_q    (hires_q)
);

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;

    localparam int DW = 10;
    localparam int LW = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          hi_res_i;
    logic [SW-1:0] settle_i;
    logic          cmp_i;
    logic [DW-1:0] dac_code_o;
    logic          busy_o;
    logic          eoc_o;
    logic [DW-1:0] result_o;
    logic          ser_bit_o;
    logic          ser_vld_o;

    logic [DW-1:0] vin;
    bit            use_volt;
    int            checks = 0;
    int            errors = 0;

    always #5 clk = ~clk;

    // Comparator model: integer code compare, or 0.6 V against a 1 V / 1024 scale.
    always_comb begin
        if (use_volt) cmp_i = (64'd600000 * 64'd1024) >= (64'(dac_code_o) * 64'd1000000);
        else          cmp_i = (vin >= dac_code_o);
    end

    sar_ctrl #(.DATA_W(DW), .LOW_W(LW), .SETTLE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hi_res_i(hi_res_i),
        .settle_i(settle_i), .cmp_i(cmp_i), .dac_code_o(dac_code_o),
        .busy_o(busy_o), .eoc_o(eoc_o), .result_o(result_o),
        .ser_bit_o(ser_bit_o), .ser_vld_o(ser_vld_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(input int v, input bit hr);
        return hr ? v : (v >> 2);
    endfunction

    // One conversion; poke issues a start plus setting changes mid-way.
    task automatic convert(input int v, input bit hr, input int s, input bit poke,
                           input int exp_force);
        int n   = hr ? DW : LW;
        int exp = (exp_force >= 0) ? exp_force : expect_code(v, hr);
        int prev, cnt, ser, nser;
        bit low_ok = 1'b1;
        bit last_with_eoc = 1'b0;
        @(negedge clk);
        prev = int'(result_o);
        vin = DW'(v); hi_res_i = hr; settle_i = SW'(s); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !eoc_o && dac_code_o == 10'd512, "R2 start", int'(dac_code_o), 512);
        cnt = 0; ser = 0; nser = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (ser_vld_o) begin
                ser = (ser << 1) | int'(ser_bit_o);
                nser++;
            end
            if (busy_o && !hr && dac_code_o[1:0] != 2'b00) low_ok = 1'b0;
            if (cnt == 1) chk(result_o == DW'(prev), "R11 result held", int'(result_o), prev);
            if (poke && cnt == 2) begin
                start_i = 1'b1; hi_res_i = ~hr; settle_i = SW'(s ^ 3);
            end
            if (poke && cnt == 3) start_i = 1'b0;
            if (eoc_o) begin
                last_with_eoc = ser_vld_o;
                break;
            end
            if (cnt > 400) break;
        end
        chk(cnt == n * (s + 1), poke ? "R9 R8 R4 timing" : "R4 timing", cnt, n * (s + 1));
        chk(result_o == DW'(exp), hr ? (poke ? "R9 result" : "R3 R6 result")
                                     : "R7 result", int'(result_o), exp);
        chk(ser == exp && nser == n, "R10 serial word", ser, exp);
        chk(last_with_eoc, "R10 last strobe with eoc", int'(last_with_eoc), 1);
        if (!hr) chk(low_ok, "R7 narrow dac", int'(low_ok), 1);
        chk(!busy_o, "R5 idle at eoc", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        chk(eoc_o && !busy_o, "R5 eoc held", int'(eoc_o), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; hi_res_i = 1'b1; settle_i = '0;
        vin = '0; use_volt = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !eoc_o && !ser_vld_o && dac_code_o == '0 && result_o == '0,
            "R1 reset", int'(result_o), 0);
        rst_n = 1'b1;

        use_volt = 1'b1;
        convert(0, 1'b1, 0, 1'b0, 614);          // R6
        use_volt = 1'b0;
        convert(0,    1'b1, 0, 1'b0, -1);        // R3
        convert(1023, 1'b1, 1, 1'b0, -1);        // R3
        convert(512,  1'b1, 7, 1'b0, -1);        // R4
        convert(511,  1'b1, 2, 1'b0, -1);        // R3
        convert(1023, 1'b0, 0, 1'b0, -1);        // R7
        convert(3,    1'b0, 3, 1'b0, -1);        // R7
        convert(700,  1'b1, 2, 1'b1, -1);        // R9 R8
        convert(301,  1'b0, 1, 1'b1, -1);        // R9 R8

        void'($urandom(32'd2024));
        for (int k = 0; k < 30; k++) begin
            convert(int'($urandom % 1024), bit'($urandom % 2), int'($urandom % 8),
                    bit'(($urandom % 4) == 0), -1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule